// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block takes a 4-bit condition predicate and the three condition bits left by an earlier floating-point compare or test: not-a-number, zero and negative. It decides whether the condition holds. The predicate set follows IEEE rules for unordered operands. A NaN makes every ordered comparison false, and it makes every "not"-form comparison true. The block drives a true/false flag and a matching all-ones or all-zeros result byte, which a set-on-condition operation can store directly.

A fifth input asks for signalling behaviour. When it is set and the NaN bit is set, the block raises an unordered-signal event. If the trap enable is also set, the block reports an abort and forces the result to false, so the consuming instruction can be dropped before it has any effect. If the trap enable is clear, the event is still reported and the predicate result passes through unchanged.

All outputs are registered and appear one cycle after an input strobe, together with a valid flag.

Top module: `fpcond_eval`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `res_valid`, `res_true`, `res_byte`, `unord_evt` and `trap_abort` are all zero.
- R2: `res_valid` is high exactly one cycle after a cycle with `in_valid` high. In a cycle where `res_valid` is low, all other outputs are zero.
- R3: Predicate 0 is never true and predicate 15 is always true. Predicate 1 is true when zero is set, and predicate 14 is true when zero is clear.
- R4: Predicate 2 evaluates !(nan|zero|neg), predicate 3 evaluates zero|!(nan|neg), predicate 4 evaluates neg&!(nan|zero), and predicate 5 evaluates zero|(neg&!nan).
- R5: Predicate 6 evaluates !(nan|zero), predicate 7 evaluates !nan, and predicate 8 evaluates nan.
- R6: Predicate 9 evaluates nan|zero, predicate 10 evaluates nan|!(neg|zero), predicate 11 evaluates nan|zero|!neg, predicate 12 evaluates nan|(neg&!zero), and predicate 13 evaluates nan|zero|neg.
- R7: `unord_evt` is high in the result cycle exactly when `sig_unord` and `cc_nan` were both high with the strobe.
- R8: `trap_abort` is high exactly when the event of R7 occurs and `trap_en` is high. In that cycle `res_true` is low and `res_byte` is 0x00, whatever the predicate.
- R9: When the event of R7 occurs with `trap_en` low, `res_true` equals the predicate result of R3 to R6.
- R10: While `res_valid` is high, `res_byte` is 0xFF when `res_true` is high and 0x00 when it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Evaluation request strobe |
| pred | input | 4 | Condition predicate code |
| sig_unord | input | 1 | Signal when the operands are unordered |
| cc_nan | input | 1 | Condition bit: not a number |
| cc_zero | input | 1 | Condition bit: zero |
| cc_neg | input | 1 | Condition bit: negative |
| trap_en | input | 1 | Unordered-signal trap enable |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res_true | output | 1 | Predicate holds |
| res_byte | output | 8 | Set-on-condition byte, all ones or all zeros |
| unord_evt | output | 1 | Unordered-signal event |
| trap_abort | output | 1 | Operation abandoned because of the trap |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle valid latency and the quiet outputs between results;
- the event and abort conditions against the delayed inputs;
- the forced-false result during an abort;
- the byte tracking the flag;
- the fixed predicates 0, 15 and 8.

The full 16-entry truth table is shown only by the bench's scenarios. They sweep every predicate across all eight flag combinations and add random traffic. This includes flag combinations that a real compare never produces, such as NaN together with zero. These scenarios also cover the event raised while the trap is disabled, where the result must still follow the predicate.

// File: rtl/fpcond_pkg.sv
package fpcond_pkg;

  localparam int PRED_W   = 4;
  localparam int NUM_PRED = 1 << PRED_W;

  typedef struct packed {
    logic nan;
    logic zero;
    logic neg;
  } ccbits_t;

  typedef enum logic [PRED_W-1:0] {
    P_NEVER   = 4'd0,
    P_EQ      = 4'd1,
    P_GT      = 4'd2,
    P_GE      = 4'd3,
    P_LT      = 4'd4,
    P_LE      = 4'd5,
    P_GL      = 4'd6,
    P_ORD     = 4'd7,
    P_UNORD   = 4'd8,
    P_NGL     = 4'd9,
    P_NLE     = 4'd10,
    P_NLT     = 4'd11,
    P_NGE     = 4'd12,
    P_NGT     = 4'd13,
    P_NE      = 4'd14,
    P_ALWAYS  = 4'd15
  } pred_e;

  // IEEE-aware evaluation: NaN falsifies ordered forms, satisfies negated forms
  function automatic logic pred_eval(input pred_e code, input ccbits_t c);
    logic r;
    unique case (code)
      P_NEVER:  r = 1'b0;
      P_EQ:     r = c.zero;
      P_GT:     r = ~(c.nan | c.zero | c.neg);
      P_GE:     r = c.zero | ~(c.nan | c.neg);
      P_LT:     r = c.neg & ~(c.nan | c.zero);
      P_LE:     r = c.zero | (c.neg & ~c.nan);
      P_GL:     r = ~(c.nan | c.zero);
      P_ORD:    r = ~c.nan;
      P_UNORD:  r = c.nan;
      P_NGL:    r = c.nan | c.zero;
      P_NLE:    r = c.nan | ~(c.neg | c.zero);
      P_NLT:    r = c.nan | c.zero | ~c.neg;
      P_NGE:    r = c.nan | (c.neg & ~c.zero);
      P_NGT:    r = c.nan | c.zero | c.neg;
      P_NE:     r = ~c.zero;
      P_ALWAYS: r = 1'b1;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpcond_table.sv
module fpcond_table
  import fpcond_pkg::*;
(
  input  logic [PRED_W-1:0] code,
  input  ccbits_t           cc,
  output logic              hit
);

  logic [NUM_PRED-1:0] row_hit;

  // One evaluator per predicate code, selected by the incoming code
  for (genvar g = 0; g < NUM_PRED; g++) begin : g_row
    assign row_hit[g] = pred_eval(pred_e'(g), cc);
  end

  assign hit = row_hit[code];

endmodule

// File: rtl/fpcond_unord.sv
module fpcond_unord (
  input  logic sig_req,
  input  logic nan,
  input  logic trap_en,
  input  logic pred_hit,
  output logic evt,
  output logic kill,
  output logic final_hit
);

  assign evt       = sig_req & nan;
  assign kill      = evt & trap_en;
  assign final_hit = pred_hit & ~kill;

endmodule

// File: rtl/fpcond_outreg.sv
module fpcond_outreg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              hit,
  input  logic              evt,
  input  logic              kill,
  output logic              q_valid,
  output logic              q_true,
  output logic [BYTE_W-1:0] q_byte,
  output logic              q_evt,
  output logic              q_kill
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_true  <= 1'b0;
      q_byte  <= '0;
      q_evt   <= 1'b0;
      q_kill  <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_true  <= in_valid & hit;
      q_byte  <= {BYTE_W{in_valid & hit}};
      q_evt   <= in_valid & evt;
      q_kill  <= in_valid & kill;
    end
  end

endmodule

// File: rtl/fpcond_eval.sv
module fpcond_eval
  import fpcond_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        pred,
  input  logic              sig_unord,
  input  logic              cc_nan,
  input  logic              cc_zero,
  input  logic              cc_neg,
  input  logic              trap_en,
  output logic              res_valid,
  output logic              res_true,
  output logic [BYTE_W-1:0] res_byte,
  output logic              unord_evt,
  output logic              trap_abort
);

  ccbits_t cc;
  logic    raw_hit;
  logic    evt_c;
  logic    kill_c;
  logic    hit_c;

  assign cc = '{nan: cc_nan, zero: cc_zero, neg: cc_neg};

  fpcond_table u_table (
    .code (pred),
    .cc   (cc),
    .hit  (raw_hit)
  );

  fpcond_unord u_unord (
    .sig_req   (sig_unord),
    .nan       (cc_nan),
    .trap_en   (trap_en),
    .pred_hit  (raw_hit),
    .evt       (evt_c),
    .kill      (kill_c),
    .final_hit (hit_c)
  );

  fpcond_outreg #(.BYTE_W(BYTE_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .hit      (hit_c),
    .evt      (evt_c),
    .kill     (kill_c),
    .q_valid  (res_valid),
    .q_true   (res_true),
    .q_byte   (res_byte),
    .q_evt    (unord_evt),
    .q_kill   (trap_abort)
  );

endmodule

// File: rtl/fpcond_eval_chk.sv
module fpcond_eval_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        pred,
  input logic              sig_unord,
  input logic              cc_nan,
  input logic              trap_en,
  input logic              res_valid,
  input logic              res_true,
  input logic [BYTE_W-1:0] res_byte,
  input logic              unord_evt,
  input logic              trap_abort
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_true && res_byte == '0 && !unord_evt && !trap_abort)); // R2
  AST_EVT_COND: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> unord_evt == $past(sig_unord && cc_nan)); // R7
  AST_ABORT_COND: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> trap_abort == $past(sig_unord && cc_nan && trap_en)); // R8
  AST_ABORT_FALSE: assert property (@(posedge clk) disable iff (rst)
    trap_abort |-> (!res_true && res_byte == '0)); // R8
  AST_BYTE_TRACKS: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_byte == (res_true ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}}))); // R10
  AST_NEVER_FALSE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred == 4'd0) |=> !res_true); // R3
  AST_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred == 4'd15 && !(sig_unord && cc_nan && trap_en)) |=> res_true); // R3
  AST_UNORD_PRED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred == 4'd8 && !trap_en) |=> res_true == $past(cc_nan)); // R5

endmodule

bind fpcond_eval fpcond_eval_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .pred       (pred),
  .sig_unord  (sig_unord),
  .cc_nan     (cc_nan),
  .trap_en    (trap_en),
  .res_valid  (res_valid),
  .res_true   (res_true),
  .res_byte   (res_byte),
  .unord_evt  (unord_evt),
  .trap_abort (trap_abort)
);

// File: tb/fpcond_eval_tb.sv
module fpcond_eval_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [3:0] pred;
  logic       sig_unord, cc_nan, cc_zero, cc_neg, trap_en;
  logic       res_valid, res_true, unord_evt, trap_abort;
  logic [7:0] res_byte;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fpcond_eval u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pred(pred),
    .sig_unord(sig_unord), .cc_nan(cc_nan), .cc_zero(cc_zero), .cc_neg(cc_neg),
    .trap_en(trap_en), .res_valid(res_valid), .res_true(res_true),
    .res_byte(res_byte), .unord_evt(unord_evt), .trap_abort(trap_abort)
  );

  // Reference truth table written from the requirement text (R3..R6)
  function automatic bit ref_pred(input int code, input bit nn, input bit zz, input bit ng);
    case (code)
      0:  return 0;
      1:  return zz;
      2:  return !nn && !zz && !ng;
      3:  return zz || (!nn && !ng);
      4:  return ng && !nn && !zz;
      5:  return zz || (ng && !nn);
      6:  return !nn && !zz;
      7:  return !nn;
      8:  return nn;
      9:  return nn || zz;
      10: return nn || (!ng && !zz);
      11: return nn || zz || !ng;
      12: return nn || (ng && !zz);
      13: return nn || zz || ng;
      14: return !zz;
      default: return 1;
    endcase
  endfunction

  function automatic string tag_of(input int code, input bit ev, input bit te);
    if (ev && te) return "R8";
    if (ev)       return "R9";
    if (code == 0 || code == 1 || code == 14 || code == 15) return "R3";
    if (code >= 2 && code <= 5) return "R4";
    if (code >= 6 && code <= 8) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Issue one request at negedge, check at the next negedge
  task automatic run_one(input int code, input bit sg, input bit nn, input bit zz,
                         input bit ng, input bit te);
    bit ev, ab, t;
    logic [11:0] e;
    in_valid = 1; pred = 4'(code); sig_unord = sg;
    cc_nan = nn; cc_zero = zz; cc_neg = ng; trap_en = te;
    ev = sg && nn;
    ab = ev && te;
    t  = ref_pred(code, nn, zz, ng) && !ab;
    e  = {1'b1, t, {8{t}}, ev, ab};
    @(negedge clk);
    chk(tag_of(code, ev, te), {res_valid, res_true, res_byte, unord_evt, trap_abort}, e);
    if (ev) chk("R7", {11'd0, unord_evt}, 12'd1);
    chk("R10", {4'd0, res_byte}, {4'd0, {8{res_true}}});
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; in_valid = 1; pred = 4'd15; sig_unord = 0;
    cc_nan = 0; cc_zero = 0; cc_neg = 0; trap_en = 0;
    repeat (3) @(negedge clk);
    chk("R1", {res_valid, res_true, res_byte, unord_evt, trap_abort}, 12'd0);
    rst = 0; in_valid = 0;
    @(negedge clk);
    chk("R1", {res_valid, res_true, res_byte, unord_evt, trap_abort}, 12'd0);

    // Full table sweep without signalling
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 8; f++)
        run_one(c, 0, f[2], f[1], f[0], f[0]);

    // Signalling corner cases: NaN with trap on and off, non-NaN with signal set
    for (int c = 0; c < 16; c++) begin
      run_one(c, 1, 1, 0, 0, 1);
      run_one(c, 1, 1, 0, 1, 0);
      run_one(c, 1, 0, 1, 0, 1);
    end

    // Idle gap: outputs go quiet
    in_valid = 0; pred = 4'd15; cc_nan = 1; sig_unord = 1; trap_en = 1;
    @(negedge clk);
    chk("R2", {res_valid, res_true, res_byte, unord_evt, trap_abort}, 12'd0);
    @(negedge clk);
    chk("R2", {res_valid, res_true, res_byte, unord_evt, trap_abort}, 12'd0);

    // Random traffic with occasional idle cycles
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 4) == 0) begin
        in_valid = 0;
        pred = 4'($urandom_range(0, 15));
        @(negedge clk);
        chk("R2", {res_valid, res_true, res_byte, unord_evt, trap_abort}, 12'd0);
      end else begin
        run_one(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
    end

    in_valid = 0;
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule